// File: doc/BRIEF.md
# Pad Drive Register Pair with Half-Word Masked Update

This block holds the two words that steer a bank of general-purpose pads: the drive value word and the drive enable word. Each word is continuously presented at the block's outputs toward the pad logic. Software updates either word in one of two ways. The first is a full-word write that replaces every bit. The second is a masked update of one half of the word, where one write carries both a bit mask and new values. This lets independent software threads change a few pins without a read-modify-write sequence.

Writes arrive on a parameterised number of simple write ports, so several bus masters may be wired to the block. Each port carries a 3-bit register select. Bit 2 of the select picks the target word (0 = drive value, 1 = drive enable). Bits 1:0 pick the access kind (0 = full word, 1 = lower half masked, 2 = upper half masked, 3 = unused). A single combinational read port returns the readback for any register select. When accesses to the same word meet in one cycle, they are resolved in a fixed order.

Top module: `pad_drive_regs`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, both the drive value word (`pad_out`) and the drive enable word (`pad_oe`) are all zeros.
- R2: A full-word write (select bits 1:0 = 0) replaces all 32 bits of the target word. A full-word read returns all 32 stored bits.
- R3: A lower-half masked write (select bits 1:0 = 1) takes the mask from write bits 31:16 and the data from write bits 15:0. Stored bit i (i in 15:0) takes data bit i only where mask bit i is 1. All other stored bits keep their value, including the whole upper half.
- R4: An upper-half masked write (select bits 1:0 = 2) uses the same mask and data fields, applied to stored bits 31:16. Stored bit 16+i takes data bit i only where mask bit i is 1. The lower half is unchanged.
- R5: A masked read returns the selected 16-bit half of the stored word in bits 15:0, and zeros in bits 31:16.
- R6: Writes to the drive value word (select bit 2 = 0) never change the drive enable word, and writes to the drive enable word (select bit 2 = 1) never change the drive value word.
- R7: When several access kinds hit one word in the same cycle, they are applied in sequence: first the full-word write, then the lower-half masked write on that result, then the upper-half masked write.
- R8: When two ports issue the same access kind to the same word in one cycle, the port with the lower index is used and the other is ignored.
- R9: Selects 3 and 7 are unused. Writes to them change neither word, and reads of them return zero.
- R10: A write becomes visible on `pad_out`/`pad_oe` and on the read port after the next rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | N_WR_PORTS | Write strobe, one per port |
| wr_addr | input | N_WR_PORTS x 3 | Register select per port: bit 2 chooses the word, bits 1:0 the access kind |
| wr_data | input | N_WR_PORTS x 32 | Write word per port; for masked kinds, mask in 31:16 and data in 15:0 |
| rd_addr | input | 3 | Register select for readback |
| rd_data | output | 32 | Readback for `rd_addr`, combinational |
| pad_out | output | 32 | Stored drive value word toward the pads |
| pad_oe | output | 32 | Stored drive enable word toward the pads |

## Verification
The per-write properties assume that port 0 is the only writer of the target word in that cycle, and that the strobes and selects are at known levels after reset. Properties that relate a word across a clock edge are enabled only when no other port hits that word. The bench drives every input on the falling clock edge and holds it stable through the next rising edge. Every collision case is built from just two ports with chosen selects, so each multi-writer cycle has one expected result that can be worked out by hand.

// File: rtl/pad_drive_pkg.sv
// Package: shared select encoding for the pad drive register pair.
// Assumes a 3-bit register select: bit 2 picks the word, bits 1:0 the access kind.
package pad_drive_pkg;

    localparam int unsigned SEL_W     = 3;
    localparam int unsigned N_WORDS   = 2;
    localparam int unsigned N_KINDS   = 3;

    localparam logic WORD_VALUE  = 1'b0;
    localparam logic WORD_ENABLE = 1'b1;

    typedef enum logic [1:0] {
        ACC_FULL  = 2'd0,
        ACC_LOWER = 2'd1,
        ACC_UPPER = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/wr_path_decode.sv
// Module: wr_path_decode
// Collects, for one target word, the write request of each access kind from all
// write ports. When several ports request the same kind, the lowest index wins.
// Assumes the select encoding of pad_drive_pkg.
module wr_path_decode
    import pad_drive_pkg::*;
#(
    parameter int unsigned N_WR_PORTS = 2,
    parameter int unsigned WORD_W     = 32,
    parameter logic        WORD_SEL   = 1'b0
) (
    input  logic [N_WR_PORTS-1:0]             wr_en,
    input  logic [N_WR_PORTS-1:0][SEL_W-1:0]  wr_addr,
    input  logic [N_WR_PORTS-1:0][WORD_W-1:0] wr_data,
    output logic [N_KINDS-1:0]                kind_hit,
    output logic [N_KINDS-1:0][WORD_W-1:0]    kind_data
);

    // Scan ports from highest to lowest index so the lowest index overwrites last.
    always_comb begin
        kind_hit  = '0;
        kind_data = '0;
        for (int p = N_WR_PORTS - 1; p >= 0; p--) begin
            if (wr_en[p] && (wr_addr[p][2] == WORD_SEL)) begin
                case (acc_kind_e'(wr_addr[p][1:0]))
                    ACC_FULL: begin
                        kind_hit[0]  = 1'b1;
                        kind_data[0] = wr_data[p];
                    end
                    ACC_LOWER: begin
                        kind_hit[1]  = 1'b1;
                        kind_data[1] = wr_data[p];
                    end
                    ACC_UPPER: begin
                        kind_hit[2]  = 1'b1;
                        kind_data[2] = wr_data[p];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/masked_word_reg.sv
// Module: masked_word_reg
// One stored word, updated by a full-word load followed by per-half masked merges.
// Assumes WORD_W is even. For a masked request, the mask is in the upper half of
// the request word and the data is in the lower half.
module masked_word_reg
    import pad_drive_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_KINDS-1:0]             kind_hit,
    input  logic [N_KINDS-1:0][WORD_W-1:0] kind_data,
    output logic [WORD_W-1:0]              word_q
);

    localparam int unsigned HALF_W   = WORD_W / 2;
    localparam int unsigned N_HALVES = 2;

    logic [N_HALVES:0][WORD_W-1:0] stage;

    // Stage 0: the full-word load, or the held value.
    always_comb begin
        stage[0] = kind_hit[0] ? kind_data[0] : word_q;
    end

    // Stages 1..2: merge the lower half, then the upper half, under their masks.
    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        logic [HALF_W-1:0] mask_h;
        logic [HALF_W-1:0] data_h;
        logic [HALF_W-1:0] prev_h;

        assign mask_h = kind_data[h+1][WORD_W-1:HALF_W];
        assign data_h = kind_data[h+1][HALF_W-1:0];
        assign prev_h = stage[h][h*HALF_W +: HALF_W];

        // Replace only the masked bits of half h when that kind is requested.
        always_comb begin
            stage[h+1] = stage[h];
            if (kind_hit[h+1]) begin
                stage[h+1][h*HALF_W +: HALF_W] = (prev_h & ~mask_h) | (data_h & mask_h);
            end
        end
    end

    // Storage register with synchronous active-low reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= stage[N_HALVES];
        end
    end

endmodule

// File: rtl/readback_mux.sv
// Module: readback_mux
// Combinational readback of both stored words for any register select.
// A masked select returns its half zero-extended; unused selects return zero.
module readback_mux
    import pad_drive_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic [SEL_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0] value_q,
    input  logic [WORD_W-1:0] enable_q,
    output logic [WORD_W-1:0] rd_data
);

    localparam int unsigned HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] picked;

    // Choose the word, then shape it by access kind.
    always_comb begin
        picked = (rd_addr[2] == WORD_ENABLE) ? enable_q : value_q;
        case (acc_kind_e'(rd_addr[1:0]))
            ACC_FULL:  rd_data = picked;
            ACC_LOWER: rd_data = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
            ACC_UPPER: rd_data = {{HALF_W{1'b0}}, picked[WORD_W-1:HALF_W]};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pad_drive_regs.sv
// Module: pad_drive_regs (top)
// Drive value and drive enable words, each with full-word and half-word masked
// write paths, shared by N_WR_PORTS write ports, plus one combinational read port.
// Assumes a synchronous active-low reset. Pad multiplexing lies outside this block.
module pad_drive_regs
    import pad_drive_pkg::*;
#(
    parameter int unsigned N_WR_PORTS = 2,
    parameter int unsigned WORD_W     = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_WR_PORTS-1:0]             wr_en,
    input  logic [N_WR_PORTS-1:0][SEL_W-1:0]  wr_addr,
    input  logic [N_WR_PORTS-1:0][WORD_W-1:0] wr_data,
    input  logic [SEL_W-1:0]                  rd_addr,
    output logic [WORD_W-1:0]                 rd_data,
    output logic [WORD_W-1:0]                 pad_out,
    output logic [WORD_W-1:0]                 pad_oe
);

    logic [N_WORDS-1:0][WORD_W-1:0] word_q;

    // One decode and one storage word per target; index 0 drive value, 1 drive enable.
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic [N_KINDS-1:0]             kind_hit;
        logic [N_KINDS-1:0][WORD_W-1:0] kind_data;

        wr_path_decode #(
            .N_WR_PORTS (N_WR_PORTS),
            .WORD_W     (WORD_W),
            .WORD_SEL   (w[0])
        ) u_decode (
            .wr_en     (wr_en),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .kind_hit  (kind_hit),
            .kind_data (kind_data)
        );

        masked_word_reg #(
            .WORD_W (WORD_W)
        ) u_word (
            .clk       (clk),
            .rst_n     (rst_n),
            .kind_hit  (kind_hit),
            .kind_data (kind_data),
            .word_q    (word_q[w])
        );
    end

    readback_mux #(
        .WORD_W (WORD_W)
    ) u_readback (
        .rd_addr  (rd_addr),
        .value_q  (word_q[0]),
        .enable_q (word_q[1]),
        .rd_data  (rd_data)
    );

    // Pad-facing outputs are the stored words themselves.
    assign pad_out = word_q[0];
    assign pad_oe  = word_q[1];

endmodule

// File: rtl/pad_drive_regs_chk.sv
// Module: pad_drive_regs_chk
// Port-level properties of pad_drive_regs, attached with bind.
// Assumes the per-write properties see port 0 as the only writer of that word.
module pad_drive_regs_chk
    import pad_drive_pkg::*;
#(
    parameter int unsigned N_WR_PORTS = 2,
    parameter int unsigned WORD_W     = 32
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [N_WR_PORTS-1:0]             wr_en,
    input logic [N_WR_PORTS-1:0][SEL_W-1:0]  wr_addr,
    input logic [N_WR_PORTS-1:0][WORD_W-1:0] wr_data,
    input logic [SEL_W-1:0]                  rd_addr,
    input logic [WORD_W-1:0]                 rd_data,
    input logic [WORD_W-1:0]                 pad_out,
    input logic [WORD_W-1:0]                 pad_oe
);

    localparam int unsigned HALF_W = WORD_W / 2;

    logic any_val_wr;
    logic any_oe_wr;
    logic other_val_wr;
    logic p0_val;

    // Summarise which ports request each word in this cycle.
    always_comb begin
        any_val_wr   = 1'b0;
        any_oe_wr    = 1'b0;
        other_val_wr = 1'b0;
        for (int p = 0; p < N_WR_PORTS; p++) begin
            if (wr_en[p] && wr_addr[p][1:0] != 2'd3) begin
                if (wr_addr[p][2]) any_oe_wr = 1'b1;
                else               any_val_wr = 1'b1;
                if (p != 0 && !wr_addr[p][2]) other_val_wr = 1'b1;
            end
        end
        p0_val = wr_en[0] && !wr_addr[0][2] && !other_val_wr;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_out == '0 && pad_oe == '0)); // R1

    AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_val && wr_addr[0][1:0] == 2'd0) |=> (pad_out == $past(wr_data[0]))); // R2

    AST_LOWER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_val && wr_addr[0][1:0] == 2'd1) |=>
        (((pad_out ^ $past(pad_out)) & ~{{HALF_W{1'b0}}, $past(wr_data[0][WORD_W-1:HALF_W])}) == '0)); // R3

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_val && wr_addr[0][1:0] == 2'd2) |=>
        (((pad_out ^ $past(pad_out)) & ~{$past(wr_data[0][WORD_W-1:HALF_W]), {HALF_W{1'b0}}}) == '0)); // R4

    AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[1:0] == 2'd1 || rd_addr[1:0] == 2'd2) |-> (rd_data[WORD_W-1:HALF_W] == '0)); // R5

    AST_OE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !any_oe_wr |=> $stable(pad_oe)); // R6

    AST_VAL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !any_val_wr |=> $stable(pad_out)); // R6

    AST_UNUSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[1:0] == 2'd3) |-> (rd_data == '0)); // R9

endmodule

bind pad_drive_regs pad_drive_regs_chk #(
    .N_WR_PORTS (N_WR_PORTS),
    .WORD_W     (WORD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/pad_drive_regs_test.sv
`timescale 1ns/1ps
// Directed bench for pad_drive_regs: one task per scenario, each checking itself.
module pad_drive_regs_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       wr_en = '0;
    logic [1:0][2:0]  wr_addr = '0;
    logic [1:0][31:0] wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic [31:0]      pad_out;
    logic [31:0]      pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pad_drive_regs #(.N_WR_PORTS(2), .WORD_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_check(input string req, input logic [2:0] sel, input logic [31:0] exp);
        rd_addr = sel;
        #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic wr1(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 2'b01; wr_addr[0] = a; wr_data[0] = d;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wr2(input logic [2:0] a0, input logic [31:0] d0,
                       input logic [2:0] a1, input logic [31:0] d1);
        @(negedge clk);
        wr_en = 2'b11; wr_addr[0] = a0; wr_data[0] = d0; wr_addr[1] = a1; wr_data[1] = d1;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 value in reset", pad_out, 32'h0);
        check("R1 enable in reset", pad_oe, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 value after release", pad_out, 32'h0);
        read_check("R1 enable readback", 3'd4, 32'h0);
    endtask

    task automatic t_full;
        wr1(3'd0, 32'h5A3C_96E1);
        check("R2 full write value", pad_out, 32'h5A3C_96E1);
        read_check("R2 full read", 3'd0, 32'h5A3C_96E1);
        check("R6 enable untouched", pad_oe, 32'h0);
    endtask

    task automatic t_lower;
        wr1(3'd1, 32'h00F0_1234);
        check("R3 lower masked", pad_out, 32'h5A3C_9631);
        wr1(3'd1, 32'h0000_FFFF);
        check("R3 zero mask no change", pad_out, 32'h5A3C_9631);
    endtask

    task automatic t_upper;
        wr1(3'd2, 32'hFF00_ABCD);
        check("R4 upper masked", pad_out, 32'hAB3C_9631);
        wr1(3'd2, 32'hFFFF_0001);
        check("R4 full mask", pad_out, 32'h0001_9631);
    endtask

    task automatic t_readback;
        read_check("R5 lower read", 3'd1, 32'h0000_9631);
        read_check("R5 upper read", 3'd2, 32'h0000_0001);
    endtask

    task automatic t_enable;
        wr1(3'd4, 32'hFFFF_0000);
        check("R2 enable full", pad_oe, 32'hFFFF_0000);
        wr1(3'd5, 32'h0101_FFFF);
        check("R3 enable lower", pad_oe, 32'hFFFF_0101);
        wr1(3'd6, 32'h8000_0000);
        check("R4 enable upper", pad_oe, 32'h7FFF_0101);
        check("R6 value untouched", pad_out, 32'h0001_9631);
        read_check("R5 enable lower read", 3'd5, 32'h0000_0101);
        read_check("R5 enable upper read", 3'd6, 32'h0000_7FFF);
    endtask

    task automatic t_order;
        wr2(3'd2, 32'h00FF_1234, 3'd0, 32'hAAAA_5555);
        check("R7 full then upper", pad_out, 32'hAA34_5555);
        wr2(3'd1, 32'hFFFF_0000, 3'd2, 32'h0F00_0F00);
        check("R7 lower and upper", pad_out, 32'hAF34_0000);
        wr2(3'd1, 32'h000F_0009, 3'd0, 32'h1234_5678);
        check("R7 full then lower", pad_out, 32'h1234_5679);
    endtask

    task automatic t_port_prio;
        wr2(3'd4, 32'h1111_2222, 3'd4, 32'h3333_4444);
        check("R8 lower port wins full", pad_oe, 32'h1111_2222);
        wr2(3'd1, 32'hFFFF_0001, 3'd1, 32'hFFFF_0002);
        check("R8 lower port wins masked", pad_out, 32'h1234_0001);
    endtask

    task automatic t_unused;
        wr1(3'd3, 32'hFFFF_FFFF);
        wr1(3'd7, 32'hFFFF_FFFF);
        check("R9 value after unused write", pad_out, 32'h1234_0001);
        check("R9 enable after unused write", pad_oe, 32'h1111_2222);
        read_check("R9 read select 3", 3'd3, 32'h0);
        read_check("R9 read select 7", 3'd7, 32'h0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        wr_en = 2'b01; wr_addr[0] = 3'd0; wr_data[0] = 32'hCAFE_F00D;
        rd_addr = 3'd0;
        #1;
        check("R10 not before edge", pad_out, 32'h1234_0001);
        check("R10 read not before edge", rd_data, 32'h1234_0001);
        @(posedge clk);
        #1;
        check("R10 after edge", pad_out, 32'hCAFE_F00D);
        @(negedge clk);
        wr_en = '0;
    endtask

    initial begin
        t_reset();
        t_full();
        t_lower();
        t_upper();
        t_readback();
        t_enable();
        t_order();
        t_port_prio();
        t_unused();
        t_timing();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule